// File: doc/BRIEF.md
# Third-Order Bitstream Decimation Filter

This block turns the single-bit, oversampled output of an external second-order sigma-delta modulator into multi-bit samples. Each modulator bit is registered on the rising edge of the system clock. The modulator clock is taken from that same clock, and the modulator data settles well after the modulator edge, so the capture edge falls clear of the data transition. The captured bits pass through a cascade of three integrators, are decimated by a fixed ratio, and then pass through three comb stages. The result is scaled and clamped to an unsigned offset-binary word.

The output code follows ones-density directly. A density of zero gives code 0, half density gives mid-scale, and a stream of all ones gives the top code instead of wrapping to zero. Each new word comes with a one-cycle strobe. A settled flag marks words whose history does not reach back to the reset.

Top module: `sinc3_decimator`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, all integrators, comb delays, the decimation counter and the word counter clear. After that edge, `sample_o` = 0, `sample_valid_o` = 0 and `settled_o` = 0. Output after release is identical to a fresh start.
- R2: `sample_valid_o` is high for exactly one cycle after every DECIM-th rising edge following reset release. The first pulse follows edge number DECIM (256 by default), counted from the first edge that sees `rst_n` high.
- R3: Let x[s] be the bit on `mod_bit_i` at edge s after release. Let I3(s) be the third running sum of x over edges 1..s-2 (I1(s) = sum of x[1..s-2], I2(s) = sum of I1 over 1..s-1, I3(s) = sum of I2 over 1..s-1). Let D(n) = I3(nR), with D(n≤0) = 0. Then the word that comes with pulse n is min(floor((D(n) − 3D(n−1) + 3D(n−2) − D(n−3)) / 2^(3·log2 R − OUT_W)), 2^OUT_W − 1).
- R4: A stream of zeros (0% density) yields code 0.
- R5: A bit value of 1 counts as one and 0 as zero. With DECIM = 256 and 16-bit output, settled words are 32768 for 50% density, 53248 for 81.25% density and 12288 for 18.75% density.
- R6: A stream of all ones yields 65535 and never wraps to 0.
- R7: `settled_o` is low with the first three words after reset and high with every later word.
- R8: The result stays exact over runs far longer than the range of the 25-bit accumulators. Modular wraparound in the integrators cancels in the combs.
- R9: `sample_o` and `settled_o` hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the modulator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_bit_i | input | 1 | Modulator data bit, 1 = one |
| sample_o | output | OUT_W (16) | Unsigned offset-binary output word |
| sample_valid_o | output | 1 | One-cycle strobe with each new word |
| settled_o | output | 1 | Word history is free of the reset transient |

## Verification
The bench targets the full-scale edge, the accumulator wraparound and the alignment of the decimation phase. An all-ones stream produces exactly 2^24 in the comb path, so a design without the clamp would output 0 instead of 65535. A design that sized the accumulators too narrowly, or that did not let them wrap, would diverge once the third integrator passes 2^25, which happens within a few hundred bits. A counter that is off by one edge, or a capture stage that is skipped, shifts the window by one bit. The random-bit phase and the mid-run reset show that as a wrong code or a strobe one cycle off, and the settled-flag count against the first three words catches a design that flags too early or too late.

// File: rtl/sinc3_pkg.sv
// Shared constants and width helpers for the third-order decimation filter.
// Assumes the decimation ratio is a power of two.
package sinc3_pkg;

    // Filter order: number of integrator and comb stages.
    localparam int unsigned CIC_ORDER = 3;

    // Accumulator width that holds the full-scale result ORDER*log2(R) bits plus one.
    function automatic int unsigned acc_width(input int unsigned decim);
        return CIC_ORDER * $clog2(decim) + 1;
    endfunction

endpackage

// File: rtl/sinc3_bit_capture.sv
// Registers the incoming modulator bit on the rising system clock edge.
// Assumes the modulator is clocked from the same edge, so its data changes
// well after this edge and is stable when it is sampled.
module sinc3_bit_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    output logic bit_o
);

    logic bit_q;

    // Capture one modulator bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= bit_i;
        end
    end

    assign bit_o = bit_q;

endmodule

// File: rtl/sinc3_integrators.sv
// Cascade of CIC_ORDER running-sum registers that run at the modulator rate.
// Each stage adds the previous stage's registered value. Modular wraparound is
// intended, because the comb section removes it exactly.
module sinc3_integrators
    import sinc3_pkg::*;
#(
    parameter int unsigned ACC_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_i,
    output logic [ACC_W-1:0] acc_o
);

    logic [CIC_ORDER-1:0][ACC_W-1:0] acc_q;
    logic [ACC_W-1:0]                bit_ext;

    // Zero-extend the captured bit; a one counts as +1.
    assign bit_ext = {{(ACC_W-1){1'b0}}, bit_i};

    // Advance every integrator once per clock from the previous stage's old value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q[0] <= acc_q[0] + bit_ext;
            for (int k = 1; k < int'(CIC_ORDER); k++) begin
                acc_q[k] <= acc_q[k] + acc_q[k-1];
            end
        end
    end

    assign acc_o = acc_q[CIC_ORDER-1];

endmodule

// File: rtl/sinc3_decim_counter.sv
// Counts modulator clocks and raises a one-cycle tick on the last clock of each
// decimation period. Assumes DECIM is at least 2.
module sinc3_decim_counter #(
    parameter int unsigned DECIM = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int unsigned CNT_W = (DECIM > 2) ? $clog2(DECIM) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DECIM - 1);

    logic [CNT_W-1:0] cnt_q;

    // Step the phase counter and wrap it at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);

    // R2: decimation ticks are isolated single-cycle events.
    a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o)
        else $error("a_r2_tick_isolated");

endmodule

// File: rtl/sinc3_comb_chain.sv
// CIC_ORDER differentiators that run at the decimated rate. The combinational
// output is the difference of the current decimated integrator value against
// the stored history. The delays advance only on a decimation tick.
module sinc3_comb_chain
    import sinc3_pkg::*;
#(
    parameter int unsigned ACC_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic [ACC_W-1:0] diff_o
);

    localparam logic [ACC_W-1:0] FULL_SCALE = {1'b1, {(ACC_W-1){1'b0}}};

    logic [CIC_ORDER-1:0][ACC_W-1:0] dly_q;
    logic [CIC_ORDER:0][ACC_W-1:0]   diff;

    // Form the successive differences against the previous decimated values.
    always_comb begin
        diff[0] = acc_i;
        for (int k = 0; k < int'(CIC_ORDER); k++) begin
            diff[k+1] = diff[k] - dly_q[k];
        end
    end

    // Store each stage's input for the next decimated sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else if (tick_i) begin
            for (int k = 0; k < int'(CIC_ORDER); k++) begin
                dly_q[k] <= diff[k];
            end
        end
    end

    assign diff_o = diff[CIC_ORDER];

    // R8: after wraparound the comb result still lies in [0, full scale].
    a_r8_comb_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |-> (diff_o <= FULL_SCALE))
        else $error("a_r8_comb_in_range");

endmodule

// File: rtl/sinc3_output_stage.sv
// Scales the comb result to OUT_W bits, clamps full scale to the top code, and
// registers the word with its strobe and settled flag. Assumes the comb result
// never exceeds full scale, so the clamp only acts on the all-ones density.
module sinc3_output_stage
    import sinc3_pkg::*;
#(
    parameter int unsigned ACC_W = 25,
    parameter int unsigned OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [ACC_W-1:0] comb_i,
    output logic [OUT_W-1:0] sample_o,
    output logic             valid_o,
    output logic             settled_o
);

    localparam int unsigned SHIFT   = ACC_W - 1 - OUT_W;
    localparam int unsigned WCNT_W  = $clog2(CIC_ORDER + 1);
    localparam logic [WCNT_W-1:0] WORDS_UNSETTLED = WCNT_W'(CIC_ORDER);
    localparam logic [ACC_W-1:0]  FULL_SCALE = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0]  scaled;
    logic              over;
    logic [OUT_W-1:0]  clamped;
    logic [OUT_W-1:0]  sample_q;
    logic              valid_q;
    logic              settled_q;
    logic [WCNT_W-1:0] words_q;

    // Drop the fraction bits and clamp any result above the top code.
    always_comb begin
        scaled  = comb_i >> SHIFT;
        over    = |scaled[ACC_W-1:OUT_W];
        clamped = over ? {OUT_W{1'b1}} : scaled[OUT_W-1:0];
    end

    // Load a new word on each tick; otherwise hold the word and drop the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= tick_i;
            if (tick_i) begin
                sample_q <= clamped;
            end
        end
    end

    // Count the first words after reset and raise the settled flag after them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q   <= '0;
            settled_q <= 1'b0;
        end else if (tick_i) begin
            if (words_q == WORDS_UNSETTLED) begin
                settled_q <= 1'b1;
            end else begin
                words_q <= words_q + 1'b1;
            end
        end
    end

    assign sample_o  = sample_q;
    assign valid_o   = valid_q;
    assign settled_o = settled_q;

    // R6: a full-scale comb result produces the top code, never a wrapped zero.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && comb_i == FULL_SCALE) |=> (sample_q == {OUT_W{1'b1}}))
        else $error("a_r6_no_overflow");

    // R2: every decimation tick is followed by the output strobe.
    a_r2_strobe_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> valid_q)
        else $error("a_r2_strobe_follows_tick");

    // R9: the word holds between strobes.
    a_r9_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(sample_q))
        else $error("a_r9_word_holds");

    // R7: the settled flag only rises together with a new word.
    a_r7_settled_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled_q) |-> valid_q)
        else $error("a_r7_settled_with_word");

endmodule

// File: rtl/sinc3_decimator.sv
// Third-order CIC decimator for a single-bit sigma-delta stream. Chain:
// bit capture, integrators, decimation counter, combs, scaling with clamp.
// Assumes DECIM is a power of two and at least 2, and that
// 3*log2(DECIM) >= OUT_W.
module sinc3_decimator
    import sinc3_pkg::*;
#(
    parameter int unsigned DECIM = 256,
    parameter int unsigned OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_bit_i,
    output logic [OUT_W-1:0] sample_o,
    output logic             sample_valid_o,
    output logic             settled_o
);

    localparam int unsigned ACC_W = acc_width(DECIM);

    logic             cap_bit;
    logic [ACC_W-1:0] integ_out;
    logic             dec_tick;
    logic [ACC_W-1:0] comb_out;

    sinc3_bit_capture u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (mod_bit_i),
        .bit_o (cap_bit)
    );

    sinc3_integrators #(.ACC_W(ACC_W)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (cap_bit),
        .acc_o (integ_out)
    );

    sinc3_decim_counter #(.DECIM(DECIM)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (dec_tick)
    );

    sinc3_comb_chain #(.ACC_W(ACC_W)) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (dec_tick),
        .acc_i  (integ_out),
        .diff_o (comb_out)
    );

    sinc3_output_stage #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (dec_tick),
        .comb_i    (comb_out),
        .sample_o  (sample_o),
        .valid_o   (sample_valid_o),
        .settled_o (settled_o)
    );

endmodule

// File: tb/sinc3_decimator_tb.sv
// Bench: a behavioural running-sum model in unbounded integers, compared with
// the design after every clock edge.
module sinc3_decimator_tb_top;

    localparam int    R     = 256;
    localparam int    W     = 16;
    localparam longint TOPC = 65535;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_i = 1'b0;
    logic [W-1:0]  sample_o;
    logic          sample_valid_o;
    logic          settled_o;

    always #5 clk = ~clk;

    sinc3_decimator #(.DECIM(R), .OUT_W(W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .mod_bit_i      (bit_i),
        .sample_o       (sample_o),
        .sample_valid_o (sample_valid_o),
        .settled_o      (settled_o)
    );

    // Reference model state.
    longint m_cap, m_s1, m_s2, m_s3;
    longint dq[$];
    int     m_edges, m_words;
    logic [W-1:0] exp_sample;
    logic   exp_valid, exp_settled, exp_in_reset;
    bit     exp_known = 0;

    // Observation state for the explicit checks.
    int     checks = 0, errors = 0;
    bit     done = 0;
    longint last_word;
    int     obs_edges, obs_words;
    int     pc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Predict the outputs after the coming edge from the bit and reset driven for it.
    task automatic model_edge(input bit b, input bit r);
        longint d0, d1, d2, d3, y, q;
        int n;
        if (!r) begin
            m_cap = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
            dq.delete();
            m_edges = 0; m_words = 0;
            exp_sample = '0; exp_valid = 1'b0; exp_settled = 1'b0;
            exp_in_reset = 1'b1;
        end else begin
            exp_in_reset = 1'b0;
            m_edges++;
            if (m_edges % R == 0) begin
                dq.push_back(m_s3);
                n  = dq.size();
                d0 = dq[n-1];
                d1 = (n >= 2) ? dq[n-2] : 0;
                d2 = (n >= 3) ? dq[n-3] : 0;
                d3 = (n >= 4) ? dq[n-4] : 0;
                y  = d0 - 3*d1 + 3*d2 - d3;
                q  = y / 256;
                if (q > TOPC) q = TOPC;
                exp_sample  = W'(q);
                exp_valid   = 1'b1;
                m_words++;
                exp_settled = (m_words > 3);
            end else begin
                exp_valid = 1'b0;
            end
            m_s3 = m_s3 + m_s2;
            m_s2 = m_s2 + m_s1;
            m_s1 = m_s1 + m_cap;
            m_cap = b;
        end
    endtask

    // Compare the design with the model, away from the active edge.
    task automatic compare();
        if (exp_in_reset) begin
            check(sample_o == '0, "R1", "sample in reset", sample_o, 0);
            check(sample_valid_o == 1'b0, "R1", "strobe in reset", sample_valid_o, 0);
            check(settled_o == 1'b0, "R1", "settled in reset", settled_o, 0);
            obs_edges = 0;
            obs_words = 0;
        end else begin
            obs_edges++;
            check(sample_valid_o == exp_valid, "R2", "strobe", sample_valid_o, exp_valid);
            check(sample_o == exp_sample, exp_valid ? "R3" : "R9", "word",
                  sample_o, exp_sample);
            check(settled_o == exp_settled, "R7", "settled model", settled_o, exp_settled);
            if (sample_valid_o) begin
                obs_words++;
                last_word = sample_o;
                if (obs_words == 1)
                    check(obs_edges == R, "R2", "edges to first strobe", obs_edges, R);
                check(settled_o == (obs_words > 3), "R7", "settled by word index",
                      settled_o, (obs_words > 3));
            end
        end
    endtask

    task automatic step(input bit b, input bit r);
        @(negedge clk);
        if (exp_known) compare();
        bit_i = b;
        rst_n = r;
        model_edge(b, r);
        exp_known = 1;
    endtask

    // mode: 0 zeros, 1 ones, 2 alternating, 3 13/16 ones, 4 3/16 ones, 5 random
    task automatic run_pattern(input int words, input int mode);
        bit b;
        for (int i = 0; i < words * R; i++) begin
            case (mode)
                0: b = 1'b0;
                1: b = 1'b1;
                2: b = pc[0];
                3: b = (pc % 16) < 13;
                4: b = (pc % 16) < 3;
                default: b = 1'($urandom_range(0, 1));
            endcase
            pc++;
            step(b, 1'b1);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);

        // R4: zero density gives code 0.
        run_pattern(6, 0);
        check(last_word == 0, "R4", "zero density", last_word, 0);

        // R5: half density gives mid-scale.
        run_pattern(6, 2);
        check(last_word == 32768, "R5", "half density", last_word, 32768);

        // R5: 81.25% density.
        run_pattern(6, 3);
        check(last_word == 53248, "R5", "13/16 density", last_word, 53248);

        // R5: 18.75% density.
        run_pattern(6, 4);
        check(last_word == 12288, "R5", "3/16 density", last_word, 12288);

        // R6: all ones clamps to the top code.
        run_pattern(6, 1);
        check(last_word == TOPC, "R6", "full density", last_word, TOPC);

        // R8: long random run, accumulators wrap many times.
        run_pattern(10, 5);

        // R1/R2/R7: reset in the middle of a period, then restart.
        for (int i = 0; i < 37; i++) step(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        run_pattern(5, 1);
        check(last_word == TOPC, "R6", "full density after reset", last_word, TOPC);
        run_pattern(4, 5);

        // Flush so that the final edge is compared as well.
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule